// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Output Latch

This block turns a serial bit stream into a parallel set of driver controls for low-side sink drivers. Bits enter on a serial data pin and move one position per rising edge of a shift clock. A separate storage clock copies the whole shift register into a holding register, and the holding register drives the outputs. So new data can be shifted in while the outputs keep showing the previous word.

Each output bit means "this driver sinks current" when it is 1. An active-low output enable and a thermal-fault input can each force every output off. Neither of them touches the stored data. One active-low clear resets the shift register, the holding register and the cascade output together. The clear is asynchronous and overrides both clocks.

Several blocks can be chained. The last shift stage is presented on a cascade output, and that output changes on the falling edge of the shift clock. The next block in the chain samples on its own rising edge. Because of the half-period gap, a downstream clock that arrives late by less than half a period still reads the correct bit.

Top module: `cascadable_sipo_latch`

## Requirements
- R1: On each rising edge of `sclk`, bit 0 of the shift register takes `ser_in` and every other bit k takes bit k-1. After 12 shifts, the first bit shifted in sits at bit 11, and after a store it appears on `drv_on[11]`.
- R2: On a rising edge of `rclk`, all 12 shift-register bits are copied into the holding register at once. Shifting alone never changes `drv_on`.
- R3: While `clr_n` is low, the shift register, the holding register and `ser_out` are all 0, and edges on `sclk` or `rclk` have no effect.
- R4: While `oe_n` is 1, `drv_on` is all zeros. The holding register keeps its contents, and they reappear on `drv_on` when `oe_n` returns to 0.
- R5: While `oe_n` is 0 and `therm_fault` is 0, `drv_on` equals the holding register. A 1 turns a driver on and a 0 leaves it off.
- R6: `ser_out` shows shift-register bit 11 and changes only on the falling edge of `sclk`. Between a rising edge and the following falling edge, it still shows bit 11 as it was before that rising edge.
- R7: While `therm_fault` is 1, `drv_on` is all zeros. When the fault clears, the previously stored data returns without a new store.
- R8: Two blocks chained through `ser_out` act as one 24-bit register. This holds when the second block's shift clock lags by less than half a period: after 24 shifts and a store, the first bit shifted in is on the second block's `drv_on[11]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clr_n | input | 1 | Asynchronous clear, active low, resets all registers |
| sclk | input | 1 | Shift clock, rising edge shifts, falling edge updates `ser_out` |
| rclk | input | 1 | Storage clock, rising edge copies shift register into holding register |
| ser_in | input | 1 | Serial data input into shift bit 0 |
| oe_n | input | 1 | Output enable, active low; high forces all outputs off |
| therm_fault | input | 1 | Thermal fault; high forces all outputs off |
| drv_on | output | 12 | Driver controls, 1 = sink driver on |
| ser_out | output | 1 | Cascade output carrying shift bit 11 |

## Verification
Several patterns are stored and read back on the outputs. An irregular word exposes reversed or shifted bit order. A single walking one, stored after one shift and after twelve shifts, pins down both ends of the register. All-ones and all-zeros words expose stuck bits. The cascade pin is sampled between a rising edge and the next falling edge, which tells a falling-edge update apart from a rising-edge one. A 24-bit pattern is then sent through two chained blocks, with the second clock lagging by three-eighths of a period. A cascade output that updates too early would shift the pattern by one place across the boundary between the blocks.

// File: rtl/sipo_latch_pkg.sv
package sipo_latch_pkg;

  // Default register length of one stage.
  localparam int unsigned DEF_WIDTH = 12;

  // Why the driver gate is or is not passing data.
  typedef enum logic [1:0] {
    DRV_PASS        = 2'd0,
    DRV_BLANK_OE    = 2'd1,
    DRV_BLANK_FAULT = 2'd2
  } drv_mode_e;

endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned W = sipo_latch_pkg::DEF_WIDTH
) (
  input  logic         sclk,
  input  logic         clr_n,
  input  logic         ser_in,
  output logic [W-1:0] stage_q,
  output logic         msb
);

  localparam int unsigned TOP = W - 1;

  // Next value of the chain: new bit enters at position 0.
  function automatic logic [W-1:0] push_bit(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  always_ff @(posedge sclk or negedge clr_n) begin
    if (!clr_n) stage_q <= '0;
    else        stage_q <= push_bit(stage_q, ser_in);
  end

  assign msb = stage_q[TOP];

  // Set by the first shift edge after a clear; marks $past as meaningful.
  logic clean_q;
  always_ff @(posedge sclk or negedge clr_n) begin
    if (!clr_n) clean_q <= 1'b0;
    else        clean_q <= 1'b1;
  end

  // R1
  shift_step_chk: assert property (@(posedge sclk) disable iff (!clr_n)
    clean_q |-> (stage_q[W-1:1] == $past(stage_q[W-2:0])) && (stage_q[0] == $past(ser_in)));

  // R3
  shift_cleared_chk: assert property (@(posedge sclk) disable iff (!clr_n)
    !clean_q |-> stage_q == '0);

endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
  parameter int unsigned W = sipo_latch_pkg::DEF_WIDTH
) (
  input  logic         rclk,
  input  logic         clr_n,
  input  logic [W-1:0] snap_in,
  output logic [W-1:0] hold_q
);

  always_ff @(posedge rclk or negedge clr_n) begin
    if (!clr_n) hold_q <= '0;
    else        hold_q <= snap_in;
  end

  logic rclean_q;
  always_ff @(posedge rclk or negedge clr_n) begin
    if (!clr_n) rclean_q <= 1'b0;
    else        rclean_q <= 1'b1;
  end

  // R2
  hold_copy_chk: assert property (@(posedge rclk) disable iff (!clr_n)
    rclean_q |-> hold_q == $past(snap_in));

  // R3
  hold_cleared_chk: assert property (@(posedge rclk) disable iff (!clr_n)
    !rclean_q |-> hold_q == '0);

endmodule

// File: rtl/sipo_cascade_tap.sv
module sipo_cascade_tap (
  input  logic sclk,
  input  logic clr_n,
  input  logic tap_in,
  output logic ser_out
);

  // Falling-edge retime gives the next stage half a period of hold.
  always_ff @(negedge sclk or negedge clr_n) begin
    if (!clr_n) ser_out <= 1'b0;
    else        ser_out <= tap_in;
  end

  logic cclean_q;
  always_ff @(negedge sclk or negedge clr_n) begin
    if (!clr_n) cclean_q <= 1'b0;
    else        cclean_q <= 1'b1;
  end

  // R6
  tap_retime_chk: assert property (@(negedge sclk) disable iff (!clr_n)
    cclean_q |-> ser_out == $past(tap_in));

  // R3
  tap_cleared_chk: assert property (@(negedge sclk) disable iff (!clr_n)
    !cclean_q |-> ser_out == 1'b0);

endmodule

// File: rtl/sipo_drive_gate.sv
module sipo_drive_gate #(
  parameter int unsigned W = sipo_latch_pkg::DEF_WIDTH
) (
  input  logic         oe_n,
  input  logic         therm_fault,
  input  logic [W-1:0] hold_q,
  output logic [W-1:0] drv_on
);
  import sipo_latch_pkg::*;

  drv_mode_e mode;

  // Fault outranks the enable; both only blank, never modify, the data.
  function automatic drv_mode_e pick_mode(input logic en_n, input logic hot);
    if (hot)  return DRV_BLANK_FAULT;
    if (en_n) return DRV_BLANK_OE;
    return DRV_PASS;
  endfunction

  always_comb begin
    mode = pick_mode(oe_n, therm_fault);
    unique case (mode)
      DRV_PASS: drv_on = hold_q;
      default:  drv_on = '0;
    endcase
  end

endmodule

// File: rtl/cascadable_sipo_latch.sv
module cascadable_sipo_latch #(
  parameter int unsigned W = sipo_latch_pkg::DEF_WIDTH
) (
  input  logic         clr_n,
  input  logic         sclk,
  input  logic         rclk,
  input  logic         ser_in,
  input  logic         oe_n,
  input  logic         therm_fault,
  output logic [W-1:0] drv_on,
  output logic         ser_out
);

  logic [W-1:0] shift_bits;
  logic [W-1:0] held_bits;
  logic         last_stage;

  sipo_shift_chain #(.W(W)) u_chain (
    .sclk    (sclk),
    .clr_n   (clr_n),
    .ser_in  (ser_in),
    .stage_q (shift_bits),
    .msb     (last_stage)
  );

  sipo_hold_reg #(.W(W)) u_hold (
    .rclk    (rclk),
    .clr_n   (clr_n),
    .snap_in (shift_bits),
    .hold_q  (held_bits)
  );

  sipo_cascade_tap u_tap (
    .sclk    (sclk),
    .clr_n   (clr_n),
    .tap_in  (last_stage),
    .ser_out (ser_out)
  );

  sipo_drive_gate #(.W(W)) u_gate (
    .oe_n        (oe_n),
    .therm_fault (therm_fault),
    .hold_q      (held_bits),
    .drv_on      (drv_on)
  );

  // R4
  oe_blank_chk: assert property (@(posedge rclk) disable iff (!clr_n)
    oe_n |-> $countones(drv_on) == 0);

  // R7
  fault_blank_chk: assert property (@(posedge rclk) disable iff (!clr_n)
    therm_fault |-> $countones(drv_on) == 0);

endmodule

// File: tb/test_cascadable_sipo_latch.sv
module test_cascadable_sipo_latch;

  localparam int W = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic clr_n = 1'b0, sclk = 1'b0, rclk = 1'b0, sin_a = 1'b0;
  logic oe_n = 1'b0, fault = 1'b0, sclk_b = 1'b0;
  logic [W-1:0] drv_a, drv_b;
  logic sout_a, sout_b;

  int checks = 0;
  int failures = 0;

  // Second stage clock lags by 3 ns, under half of the 8 ns shift period.
  always @(sclk) sclk_b <= #3 sclk;

  cascadable_sipo_latch i_cascadable_sipo_latch (
    .clr_n(clr_n), .sclk(sclk), .rclk(rclk), .ser_in(sin_a),
    .oe_n(oe_n), .therm_fault(fault), .drv_on(drv_a), .ser_out(sout_a));

  cascadable_sipo_latch i_stage_b (
    .clr_n(clr_n), .sclk(sclk_b), .rclk(rclk), .ser_in(sout_a),
    .oe_n(oe_n), .therm_fault(fault), .drv_on(drv_b), .ser_out(sout_b));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sin_a = b; #2 sclk = 1'b1; #4 sclk = 1'b0; #2;
  endtask

  // Most significant bit goes first, so after W shifts bit k holds w[k].
  task automatic shift_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic store();
    #2 rclk = 1'b1; #4 rclk = 1'b0; #2;
  endtask

  task automatic clear_all();
    clr_n = 1'b0; #4 clr_n = 1'b1; #4;
  endtask

  task automatic t_reset();
    check("R3 reset drv", drv_a, '0);
    check("R3 reset ser_out", {11'd0, sout_a}, '0);
  endtask

  task automatic t_pattern();
    clear_all();
    shift_word(12'hA5C);
    check("R2 no store yet", drv_a, '0);
    check("R6 ser_out after word", {11'd0, sout_a}, 12'd1);
    store();
    check("R1 R5 pattern A5C", drv_a, 12'hA5C);
    // Bit 11 is 1, bit 10 is 0: cascade must hold 1 until the falling edge.
    sin_a = 1'b0; #2 sclk = 1'b1; #1;
    check("R6 hold while sclk high", {11'd0, sout_a}, 12'd1);
    #3 sclk = 1'b0; #1;
    check("R6 update on fall", {11'd0, sout_a}, 12'd0);
    check("R2 drv unchanged by shift", drv_a, 12'hA5C);
    #1;
    shift_word(12'hFFF); store();
    check("R5 all ones", drv_a, 12'hFFF);
    shift_word(12'h000); store();
    check("R5 all zeros", drv_a, 12'h000);
  endtask

  task automatic t_walk();
    clear_all();
    shift_bit(1'b1); store();
    check("R1 walk one at bit0", drv_a, 12'h001);
    for (int i = 0; i < 11; i++) shift_bit(1'b0);
    check("R6 walk one on ser_out", {11'd0, sout_a}, 12'd1);
    store();
    check("R1 walk one at bit11", drv_a, 12'h800);
  endtask

  task automatic t_gating();
    clear_all();
    shift_word(12'h3C6); store();
    oe_n = 1'b1; #1;
    check("R4 oe high blanks", drv_a, '0);
    oe_n = 1'b0; #1;
    check("R4 oe low restores", drv_a, 12'h3C6);
    fault = 1'b1; #1;
    check("R7 fault blanks", drv_a, '0);
    store(); // copy of same shift data during fault
    fault = 1'b0; #1;
    check("R7 fault release restores", drv_a, 12'h3C6);
  endtask

  task automatic t_clear_override();
    shift_word(12'h5AF); store();
    clr_n = 1'b0; #1;
    check("R3 clear drops drv", drv_a, '0);
    sin_a = 1'b1; #1 sclk = 1'b1; #3 sclk = 1'b0; #1;
    rclk = 1'b1; #3 rclk = 1'b0; #1;
    check("R3 clocks ignored in clear", drv_a, '0);
    check("R3 ser_out cleared", {11'd0, sout_a}, '0);
    clr_n = 1'b1; #4;
    store();
    check("R3 shift reg was cleared", drv_a, '0);
  endtask

  task automatic t_chain(input logic [2*W-1:0] p);
    clear_all();
    for (int i = 2 * W - 1; i >= 0; i--) shift_bit(p[i]);
    #4; // let the lagging stage finish its last pulse
    store();
    check("R8 chain first stage", drv_a, p[W-1:0]);
    check("R8 chain second stage", drv_b, p[2*W-1:W]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #5 t_reset();
    clr_n = 1'b1; #3;
    t_pattern();
    t_walk();
    t_gating();
    t_clear_override();
    t_chain(24'hC3A596);
    t_chain(24'h800001);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule